// File: doc/BRIEF.md
# Adapter EEPROM Default Image Builder

This block builds the factory-default contents of a 128-byte configuration EEPROM for a SCSI host adapter. Once reset is released it writes a fixed layout into an internal image one 16-bit word per clock. It then walks the image again one word per clock and adds up the little-endian words with 16-bit wraparound. Last, it writes a checksum word into the top two bytes so that all 64 words of the image add up to a fixed target value.

Other logic reads the finished image through a byte-addressed combinational read port. A `done` flag rises when the checksum has been written and stays high until the next reset. A serial-EEPROM wire engine or a host bridge would sit on top of the read port.

Top module: `eep_default_image`

## Requirements
- R1: Byte addresses 0 to 31 hold sixteen little-endian words, each with 0x57 at the even address and 0x00 at the odd address.
- R2: Byte 64 (adapter bus ID) reads 7, byte 65 (mode flags) reads 0x0F, and byte 67 (queued-command depth) reads 0x04.
- R3: Byte 68 (boot options) reads 0x07: bit 0 boot hotkey, bit 1 optical-disc boot and bit 2 legacy disk service are set, and bit 3 (bus-scan negotiation) and bits 7:4 are clear.
- R4: Every byte in 0 to 125 that R1 to R3 do not name reads 0x00.
- R5: Bytes 126 (low) and 127 (high) hold 0x1234 minus the 16-bit wrapped sum of the words at byte offsets 0, 2, ..., 124. The result is that all 64 words sum to 0x1234.
- R6: `done` is 0 while `rst_n` is low and for at least 120 clock edges after its release.
- R7: Once `done` is 1 it stays 1 and the image does not change until reset.
- R8: Asserting reset in the middle of generation aborts it and clears `done`. After release a full regeneration produces the same image.
- R9: `done` rises no later than 140 clock edges after `rst_n` is released: one word per clock for filling, one word per clock for summing, and two cycles of reset synchronisation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_addr | input | 7 | Byte address of the image to read |
| rd_data | output | 8 | Image byte at `rd_addr` (combinational) |
| done | output | 1 | Image and checksum complete |

## Verification
The bench builds the block with its default parameters: a 128-byte image, sixteen fill words and a target of 0x1234. With these values every byte address can be swept and compared against a model computed arithmetically from the requirements. The full 64-word sum and the latency from reset release to `done` can also be checked exactly. A reset applied during the summing phase exercises the abort-and-regenerate path.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SUM  = 2'd1,
    ST_CHK  = 2'd2,
    ST_DONE = 2'd3
  } eep_state_e;
endpackage

// File: rtl/eep_default_rom.sv
// Combinational default-word generator: one byte lane per generate branch.
module eep_default_rom #(
  parameter int          WIDX_W     = 6,
  parameter int          FILL_WORDS = 16,
  parameter logic [7:0]  FILL_LO    = 8'h57,
  parameter logic [7:0]  FILL_HI    = 8'h00,
  parameter int          ID_OFS     = 64,
  parameter logic [7:0]  ID_VAL     = 8'd7,
  parameter int          MODE_OFS   = 65,
  parameter logic [7:0]  MODE_VAL   = 8'h0F,
  parameter int          TAG_OFS    = 67,
  parameter logic [7:0]  TAG_VAL    = 8'h04,
  parameter int          OPT_OFS    = 68,
  parameter logic [7:0]  OPT_VAL    = 8'h07
) (
  input  logic [WIDX_W-1:0] widx,
  output logic [15:0]       word
);
  localparam int FILL_BYTES = FILL_WORDS * 2;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [WIDX_W:0] baddr;
    logic [7:0]      bval;
    assign baddr = {widx, 1'(lane)};
    always_comb begin
      if (int'(baddr) < FILL_BYTES) begin
        bval = (lane == 0) ? FILL_LO : FILL_HI;
      end else if (int'(baddr) == ID_OFS) begin
        bval = ID_VAL;
      end else if (int'(baddr) == MODE_OFS) begin
        bval = MODE_VAL;
      end else if (int'(baddr) == TAG_OFS) begin
        bval = TAG_VAL;
      end else if (int'(baddr) == OPT_OFS) begin
        bval = OPT_VAL;
      end else begin
        bval = 8'h00;
      end
    end
    assign word[lane*8 +: 8] = bval;
  end
endmodule

// File: rtl/eep_image_store.sv
// Word-organised image: one word write port, one word read port, one byte read port.
module eep_image_store #(
  parameter int WORDS  = 64,
  parameter int WIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_widx,
  input  logic [15:0]       wr_word,
  input  logic [WIDX_W-1:0] sum_widx,
  output logic [15:0]       sum_word,
  input  logic [WIDX_W:0]   rd_addr,
  output logic [7:0]        rd_data
);
  logic [15:0] mem_q [WORDS];
  logic [15:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'h0000;
    end else if (wr_en) begin
      mem_q[wr_widx] <= wr_word;
    end
  end

  assign sum_word = mem_q[sum_widx];
  assign rd_word  = mem_q[rd_addr[WIDX_W:1]];
  assign rd_data  = rd_addr[0] ? rd_word[15:8] : rd_word[7:0];
endmodule

// File: rtl/eep_seq_ctrl.sv
// Sequencer: fill pass, sum pass, checksum write, then hold.
module eep_seq_ctrl
  import eep_pkg::*;
#(
  parameter int          WORDS  = 64,
  parameter int          WIDX_W = 6,
  parameter logic [15:0] TARGET = 16'h1234
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       sum_word,
  output logic [WIDX_W-1:0] sum_widx,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_widx,
  output logic              chk_sel,
  output logic [15:0]       chk_word,
  output logic              done
);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);
  localparam logic [WIDX_W-1:0] LAST_S = WIDX_W'(WORDS - 2);

  eep_state_e        state_q, state_n;
  logic [WIDX_W-1:0] idx_q, idx_n;
  logic [15:0]       acc_q, acc_n;
  logic              idx_en, acc_en;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    acc_n   = acc_q;
    idx_en  = 1'b0;
    acc_en  = 1'b0;
    wr_en   = 1'b0;
    chk_sel = 1'b0;
    wr_widx = idx_q;
    unique case (state_q)
      ST_FILL: begin
        wr_en  = 1'b1;
        idx_en = 1'b1;
        if (idx_q == LAST_W) begin
          idx_n   = '0;
          state_n = ST_SUM;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_SUM: begin
        acc_en = 1'b1;
        acc_n  = acc_q + sum_word;
        idx_en = 1'b1;
        if (idx_q == LAST_S) begin
          idx_n   = '0;
          state_n = ST_CHK;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end
      ST_CHK: begin
        wr_en   = 1'b1;
        chk_sel = 1'b1;
        wr_widx = LAST_W;
        state_n = ST_DONE;
      end
      default: begin
        state_n = ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_n;
    end
  end

  assign sum_widx = idx_q;
  assign chk_word = TARGET - acc_q;
  assign done     = (state_q == ST_DONE);

  // R9: summing only follows filling or summing
  a_r9_sum_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SUM) |-> ($past(state_q) == ST_FILL || $past(state_q) == ST_SUM));
  // R5: checksum write only after the sum pass
  a_r5_chk_after_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHK) |-> ($past(state_q) == ST_SUM));
  // R7: accumulated sum frozen once done
  a_r7_acc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(acc_q));
  // R7: done is sticky
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/eep_default_image.sv
module eep_default_image #(
  parameter int          IMG_BYTES  = 128,
  parameter int          FILL_WORDS = 16,
  parameter logic [15:0] TARGET     = 16'h1234,
  parameter logic [7:0]  ID_VAL     = 8'd7,
  parameter logic [7:0]  MODE_VAL   = 8'h0F,
  parameter logic [7:0]  TAG_VAL    = 8'h04,
  parameter bit          OPT_HOTKEY = 1'b1,
  parameter bit          OPT_OPTBOOT = 1'b1,
  parameter bit          OPT_LEGACY = 1'b1,
  parameter bit          OPT_BUSNEG = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(IMG_BYTES)-1:0] rd_addr,
  output logic [7:0]                   rd_data,
  output logic                         done
);
  localparam int         ADDR_W  = $clog2(IMG_BYTES);
  localparam int         WORDS   = IMG_BYTES / 2;
  localparam int         WIDX_W  = ADDR_W - 1;
  localparam logic [7:0] OPT_VAL = {4'b0000, OPT_BUSNEG, OPT_LEGACY, OPT_OPTBOOT, OPT_HOTKEY};

  logic              sync1_q, rst_n_i;
  logic              wr_en, chk_sel;
  logic [WIDX_W-1:0] wr_widx, sum_widx;
  logic [15:0]       rom_word, chk_word, wr_word, sum_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_n_i <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_n_i <= sync1_q;
    end
  end

  eep_default_rom #(
    .WIDX_W(WIDX_W), .FILL_WORDS(FILL_WORDS),
    .FILL_LO(8'h57), .FILL_HI(8'h00),
    .ID_OFS(64), .ID_VAL(ID_VAL),
    .MODE_OFS(65), .MODE_VAL(MODE_VAL),
    .TAG_OFS(67), .TAG_VAL(TAG_VAL),
    .OPT_OFS(68), .OPT_VAL(OPT_VAL)
  ) u_rom (
    .widx(wr_widx),
    .word(rom_word)
  );

  eep_seq_ctrl #(.WORDS(WORDS), .WIDX_W(WIDX_W), .TARGET(TARGET)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i),
    .sum_word(sum_word), .sum_widx(sum_widx),
    .wr_en(wr_en), .wr_widx(wr_widx),
    .chk_sel(chk_sel), .chk_word(chk_word),
    .done(done)
  );

  assign wr_word = chk_sel ? chk_word : rom_word;

  eep_image_store #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_store (
    .clk(clk), .rst_n(rst_n_i),
    .wr_en(wr_en), .wr_widx(wr_widx), .wr_word(wr_word),
    .sum_widx(sum_widx), .sum_word(sum_word),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R7: image is never written once done
  a_r7_no_write_done: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> !wr_en);
  // R5: checksum goes only to the top word
  a_r5_chk_top_word: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && chk_sel) |-> (wr_widx == WIDX_W'(WORDS - 1)));
  // R6: done low while the synchronised reset is held
  a_r6_done_in_reset: assert property (@(posedge clk)
    !rst_n_i |-> !done);
endmodule

// File: tb/sim_eep_default_image.sv
module sim_eep_default_image;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       done;

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;

  always #5 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  eep_default_image u0 (.clk(clk), .rst_n(rst_n), .rd_addr(rd_addr),
                        .rd_data(rd_data), .done(done));

  function automatic logic [7:0] base_byte(int a);
    if (a < 32) return (a % 2 == 0) ? 8'h57 : 8'h00;
    if (a == 64) return 8'd7;
    if (a == 65) return 8'h0F;
    if (a == 67) return 8'h04;
    if (a == 68) return 8'h01 | 8'h02 | 8'h04;
    return 8'h00;
  endfunction

  function automatic logic [15:0] exp_chk();
    logic [15:0] s = 16'h0000;
    for (int w = 0; w < 63; w++) s = s + {base_byte(2*w+1), base_byte(2*w)};
    return 16'h1234 - s;
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    logic [15:0] c = exp_chk();
    if (a == 126) return c[7:0];
    if (a == 127) return c[15:8];
    return base_byte(a);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = 7'(a);
    #1 v = rd_data;
  endtask

  function automatic string req_of(int a);
    if (a < 32) return "R1";
    if (a == 64 || a == 65 || a == 67) return "R2";
    if (a == 68) return "R3";
    if (a >= 126) return "R5";
    return "R4";
  endfunction

  task automatic sweep();
    logic [7:0]  v;
    logic [15:0] tot = 16'h0000;
    logic [7:0]  lo;
    for (int a = 0; a < 128; a++) begin
      rd(a, v);
      check(req_of(a), v, exp_byte(a));
      if (a % 2 == 0) lo = v; else tot = tot + {v, lo};
    end
    check("R5 total", tot, 16'h1234);
  endtask

  task automatic wait_done(output int lat);
    int start = edges;
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) begin lat = edges - start; break; end
    end
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R6 reset", done, 0);
    rst_n = 1'b1;
    repeat (120) @(negedge clk);
    check("R6 early", done, 0);
    wait_done(lat);
    lat = lat + 120;
    n_chk++;
    if (lat < 120 || lat > 140) begin
      n_fail++;
      $display("FAIL R9 actual=%0d expected=120..140", lat);
    end
    sweep();
    repeat (30) @(negedge clk);
    check("R7 sticky", done, 1);
    rd(126, v);
    check("R7 stable", v, exp_byte(126));
    // R8: reset during the sum pass
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 cleared", done, 0);
    rst_n = 1'b1;
    repeat (90) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 abort", done, 0);
    rst_n = 1'b1;
    wait_done(lat);
    check("R8 redo", done, 1);
    sweep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule